// File: doc/BRIEF.md
# Wavetable DMA Transfer Engine

This block copies a block of bytes between a system-memory byte stream and on-card wavetable RAM. Software first loads a control byte, a 16-bit page register and a 4-bit fine register. A single start pulse then carries the number of count units, the channel width and a terminal-count flag. From these values the engine works out the RAM start address and moves the data. After the block it advances the page and fine registers. If the terminal-count flag was set, it also retires the request bit and can raise an interrupt.

Toward the card, the engine takes bytes from a valid/ready source stream and writes each one into RAM, optionally inverting the sign bit. Toward the system, it reads RAM through a synchronous port with one cycle of latency and presents each byte on a valid/ready sink stream. A 16-bit channel moves two bytes per count unit and uses a doubled, bank-preserving address.

Top module: `wt_dma_engine`

## Requirements
- R1: On an 8-bit channel the first RAM address is page*16 + fine. Each byte moved adds one to the address, and the address wraps modulo 2^20.
- R2: On a 16-bit channel (`go_wide`=1), with o = page*16 + fine, the first address is (o & 0xC0000) + 2*(o & 0x1FFF0), modulo 2^20. Later bytes then count up by one.
- R3: Control bit 1 selects the direction. With 0, each accepted source byte is written to RAM. With 1, each byte read from RAM is offered on the sink stream in address order.
- R4: The sign bit (data bit 7) is inverted only when control bit 7 is 1 and control bit 1 is 0. Data read from the card is never altered.
- R5: A count unit is one byte on an 8-bit channel and two bytes on a 16-bit channel. The second byte of a 16-bit unit takes the inversion of R4. The first byte (and the only byte of an 8-bit unit) takes it only when control bit 6 is 0.
- R6: When the block ends, page becomes page + (count >> 4) modulo 2^16 and fine becomes (count + fine) & 0xF. Both are visible in the cycle in which `busy` is first low.
- R7: With the terminal-count flag set, control bit 0 reads 1 for as long as the block runs and reads 0 once `busy` falls. With the flag clear, control bit 0 is unchanged.
- R8: When the terminal-count flag and control bit 5 are both set, `irq` rises as the block ends. It stays high until `irq_ack` is pulsed. Without control bit 5, `irq` stays low.
- R9: `busy` rises the cycle after an accepted start. Start pulses while `busy` is high are ignored. A count of zero moves no byte but still updates the registers as in R6 to R8.
- R10: No RAM write happens in a cycle where the source is not valid. No read byte is lost while the sink is not ready.
- R11: Register load strobes that arrive while `busy` is high are ignored.
- R12: After reset the control, page and fine registers are zero, and `busy`, `irq`, `ram_we` and `ram_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for control, page and fine registers |
| cfg_ctl | input | 8 | Control byte value to load |
| cfg_page | input | 16 | Page register value to load |
| cfg_fine | input | 4 | Fine register value to load |
| irq_ack | input | 1 | Clears the pending interrupt |
| go | input | 1 | Start pulse for one block |
| go_count | input | 16 | Block length in count units |
| go_wide | input | 1 | 1 selects a 16-bit channel |
| go_tc | input | 1 | Terminal-count flag for this block |
| src_valid | input | 1 | Source byte is valid |
| src_data | input | 8 | Source byte from system memory |
| src_ready | output | 1 | Engine accepts a source byte |
| snk_valid | output | 1 | Sink byte is valid |
| snk_data | output | 8 | Byte read from card RAM |
| snk_ready | input | 1 | System side accepts the sink byte |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable (data returned next cycle) |
| ram_addr | output | 20 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| busy | output | 1 | Block in progress |
| ctl_q | output | 8 | Control register |
| page_q | output | 16 | Page register |
| fine_q | output | 4 | Fine register |
| irq | output | 1 | Terminal-count interrupt pending |

## Verification
The hardest case to reach from the ports is a block that is still running when a second start pulse and a register load arrive. Neither may change the byte count or the page that is later advanced. The stimulus produces this case by issuing both during a long, stalled block that starts at the top of the address space. That same block also shows the address wrapping to zero. The source and sink streams get random gaps, so the per-clock reference model sees stalls on both sides of every byte in both directions.

// File: rtl/wt_dma_pkg.sv
// Package: shared state encoding for the wavetable DMA engine.
// Assumes: nothing beyond IEEE 1800-2017.
package wt_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start pulse
        ST_PUSH = 3'd1,   // taking source bytes into RAM
        ST_RD   = 3'd2,   // issuing a RAM read
        ST_CAP  = 3'd3,   // capturing RAM read data
        ST_SEND = 3'd4,   // offering a byte on the sink stream
        ST_DONE = 3'd5    // one cycle to retire the block
    } dma_st_t;

endpackage

// File: rtl/wt_dma_addr.sv
// Module: wt_dma_addr
// Forms the RAM start address from the page and fine registers. On a
// 16-bit channel it applies bank-preserving doubling. It then counts the
// address up by one per byte moved.
// Assumes: ADDR_W = page width + FINE_W, and the address wraps naturally.
module wt_dma_addr #(
    parameter int ADDR_W = 20,
    parameter int FINE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     wide,
    input  logic [ADDR_W-FINE_W-1:0] page,
    input  logic [FINE_W-1:0]        fine,
    input  logic                     step,
    output logic [ADDR_W-1:0]        addr
);
    localparam logic [ADDR_W-1:0] BANK_M = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] MID_M  =
        ADDR_W'(((64'd1 << (ADDR_W-3)) - 64'd1) & ~((64'd1 << FINE_W) - 64'd1));

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] trans;

    // Start offset, then the 16-bit translation of it.
    always_comb begin
        base  = {page, FINE_W'(0)} + ADDR_W'(fine);
        trans = (base & BANK_M) + ((base & MID_M) << 1);
    end

    // Address register: load at start, count up per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= wide ? trans : base;
        else if (step)
            addr <= addr + ADDR_W'(1);
    end

    // R1: every byte step advances the address by exactly one, with wrap
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: rtl/wt_dma_regs.sv
// Module: wt_dma_regs
// Holds the control, page and fine registers and the interrupt flag.
// Loads them on a write strobe and advances them when a block retires.
// Assumes: wr_en and fin are never high together (the top gates writes
// with busy).
module wt_dma_regs #(
    parameter int PAGE_W = 16,
    parameter int FINE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_ctl,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [FINE_W-1:0] wr_fine,
    input  logic              fin,
    input  logic [CNT_W-1:0]  fin_count,
    input  logic              fin_tc,
    input  logic              irq_ack,
    output logic [7:0]        ctl,
    output logic [PAGE_W-1:0] page,
    output logic [FINE_W-1:0] fine,
    output logic              irq
);
    localparam int REQ_BIT = 0;
    localparam int IEN_BIT = 5;

    logic [PAGE_W-1:0] page_adv;
    logic              irq_set;

    // Values the registers take when a block retires.
    always_comb begin
        page_adv = page + PAGE_W'(fin_count >> FINE_W);
        irq_set  = fin && fin_tc && ctl[IEN_BIT];
    end

    // Register file update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl  <= '0;
            page <= '0;
            fine <= '0;
        end else if (wr_en) begin
            ctl  <= wr_ctl;
            page <= wr_page;
            fine <= wr_fine;
        end else if (fin) begin
            page <= page_adv;
            fine <= fin_count[FINE_W-1:0] + fine;
            if (fin_tc)
                ctl[REQ_BIT] <= 1'b0;
        end
    end

    // Interrupt flag: set at terminal count, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (irq_set)
            irq <= 1'b1;
        else if (irq_ack)
            irq <= 1'b0;
    end

    // R7: the request bit is clear after a terminal-count block
    a_r7_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && fin_tc) |=> !ctl[REQ_BIT]);

    // R7: a block without terminal count leaves the request bit alone
    a_r7_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !fin_tc && !wr_en) |=> (ctl[REQ_BIT] == $past(ctl[REQ_BIT])));

    // R8: interrupt raised at a terminal count with the enable set
    a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);

    // R8: interrupt never rises on its own
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_set) |=> !irq);

endmodule

// File: rtl/wt_dma_seq.sv
// Module: wt_dma_seq
// Sequencer for one block. It latches the block parameters at start and
// counts the remaining bytes. It moves source bytes into RAM with optional
// sign inversion, or reads RAM into the sink stream, and it pulses fin for
// one cycle when the block retires.
// Assumes: the RAM returns read data one cycle after ram_re.
module wt_dma_seq
    import wt_dma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_count,
    input  logic              go_wide,
    input  logic              go_tc,
    input  logic [7:0]        ctl,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data,
    input  logic              snk_ready,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic              addr_load,
    output logic              addr_step,
    output logic              fin,
    output logic [CNT_W-1:0]  fin_count,
    output logic              fin_tc
);
    localparam int REM_W   = CNT_W + 1;
    localparam int DIR_BIT = 1;
    localparam int LO_BIT  = 6;
    localparam int INV_BIT = 7;

    dma_st_t           st;
    logic [REM_W-1:0]  rem;
    logic [REM_W-1:0]  total;
    logic              inv_en;
    logic              lo_plain;
    logic              wide_q;
    logic              hi_q;
    logic              tc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hold;
    logic              inv_now;
    logic              byte_done;
    logic              last;

    // Decode of the current cycle.
    always_comb begin
        total     = go_wide ? {go_count, 1'b0} : {1'b0, go_count};
        inv_now   = inv_en && (hi_q || !lo_plain);
        src_ready = (st == ST_PUSH);
        snk_valid = (st == ST_SEND);
        snk_data  = hold;
        ram_we    = src_ready && src_valid;
        ram_re    = (st == ST_RD);
        ram_wdata = src_data ^ {inv_now, {(DATA_W-1){1'b0}}};
        byte_done = ram_we || (snk_valid && snk_ready);
        last      = (rem == REM_W'(1));
        busy      = (st != ST_IDLE);
        addr_load = (st == ST_IDLE) && go;
        addr_step = byte_done;
        fin       = (st == ST_DONE);
        fin_count = cnt_q;
        fin_tc    = tc_q;
    end

    // Block state machine with the latched parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rem      <= '0;
            inv_en   <= 1'b0;
            lo_plain <= 1'b0;
            wide_q   <= 1'b0;
            hi_q     <= 1'b0;
            tc_q     <= 1'b0;
            cnt_q    <= '0;
            hold     <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    rem      <= total;
                    cnt_q    <= go_count;
                    tc_q     <= go_tc;
                    wide_q   <= go_wide;
                    hi_q     <= 1'b0;
                    inv_en   <= ctl[INV_BIT] && !ctl[DIR_BIT];
                    lo_plain <= ctl[LO_BIT];
                    if (total == '0)
                        st <= ST_DONE;
                    else
                        st <= ctl[DIR_BIT] ? ST_RD : ST_PUSH;
                end
                ST_PUSH: if (src_valid) begin
                    rem  <= rem - REM_W'(1);
                    hi_q <= wide_q && !hi_q;
                    if (last)
                        st <= ST_DONE;
                end
                ST_RD:   st <= ST_CAP;
                ST_CAP: begin
                    hold <= ram_rdata;
                    st   <= ST_SEND;
                end
                ST_SEND: if (snk_ready) begin
                    rem <= rem - REM_W'(1);
                    st  <= last ? ST_DONE : ST_RD;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: a start pulse while busy does not disturb the latched count
    a_r9_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> $stable(cnt_q));

    // R9: the retire cycle lasts exactly one clock
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (st == ST_IDLE));

    // R10: a stalled source leaves the byte count unchanged
    a_r10_src_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && !src_valid) |=> $stable(rem));

    // R10: an offered sink byte holds until taken
    a_r10_snk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

    // R3: RAM write, RAM read and sink offer are mutually exclusive
    a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_re, snk_valid}));

endmodule

// File: rtl/wt_dma_engine.sv
// Module: wt_dma_engine (top)
// Wavetable DMA transfer engine. It joins the register file, the address
// generator and the block sequencer. Register loads are accepted only
// while idle.
// Assumes: one synchronous RAM with one-cycle read latency and one
// system-side stream pair.
module wt_dma_engine #(
    parameter int ADDR_W = 20,
    parameter int FINE_W = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [7:0]               cfg_ctl,
    input  logic [ADDR_W-FINE_W-1:0] cfg_page,
    input  logic [FINE_W-1:0]        cfg_fine,
    input  logic                     irq_ack,
    input  logic                     go,
    input  logic [CNT_W-1:0]         go_count,
    input  logic                     go_wide,
    input  logic                     go_tc,
    input  logic                     src_valid,
    input  logic [DATA_W-1:0]        src_data,
    output logic                     src_ready,
    output logic                     snk_valid,
    output logic [DATA_W-1:0]        snk_data,
    input  logic                     snk_ready,
    output logic                     ram_we,
    output logic                     ram_re,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic                     busy,
    output logic [7:0]               ctl_q,
    output logic [ADDR_W-FINE_W-1:0] page_q,
    output logic [FINE_W-1:0]        fine_q,
    output logic                     irq
);
    localparam int PAGE_W = ADDR_W - FINE_W;

    logic             wr_ok;
    logic             a_load;
    logic             a_step;
    logic             fin;
    logic [CNT_W-1:0] fin_count;
    logic             fin_tc;

    // Register loads only between blocks.
    always_comb wr_ok = cfg_wr && !busy;

    wt_dma_regs #(.PAGE_W(PAGE_W), .FINE_W(FINE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok), .wr_ctl(cfg_ctl), .wr_page(cfg_page), .wr_fine(cfg_fine),
        .fin(fin), .fin_count(fin_count), .fin_tc(fin_tc), .irq_ack(irq_ack),
        .ctl(ctl_q), .page(page_q), .fine(fine_q), .irq(irq)
    );

    wt_dma_addr #(.ADDR_W(ADDR_W), .FINE_W(FINE_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(a_load), .wide(go_wide), .page(page_q), .fine(fine_q),
        .step(a_step), .addr(ram_addr)
    );

    wt_dma_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_count(go_count), .go_wide(go_wide), .go_tc(go_tc),
        .ctl(ctl_q),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
        .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata),
        .busy(busy), .addr_load(a_load), .addr_step(a_step),
        .fin(fin), .fin_count(fin_count), .fin_tc(fin_tc)
    );

    // R11: during a block the page register changes only at retire
    a_r11_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(page_q));

    // R6: the block retires in the cycle before busy falls
    a_r6_fin_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fin));

endmodule

// File: tb/wt_dma_engine_test.sv
// Bench for wt_dma_engine. A behavioural model builds queues of expected
// RAM writes and sink bytes and compares them on every clock.
module wt_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_ctl = '0;
    logic [15:0] cfg_page = '0;
    logic [3:0]  cfg_fine = '0;
    logic        irq_ack = 1'b0;
    logic        go = 1'b0;
    logic [15:0] go_count = '0;
    logic        go_wide = 1'b0;
    logic        go_tc = 1'b0;
    logic        src_valid = 1'b0;
    logic [7:0]  src_data = '0;
    logic        src_ready;
    logic        snk_valid;
    logic [7:0]  snk_data;
    logic        snk_ready = 1'b0;
    logic        ram_we, ram_re;
    logic [19:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic        busy;
    logic [7:0]  ctl_q;
    logic [15:0] page_q;
    logic [3:0]  fine_q;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit monitor_on = 1'b0;

    int src_q[$];
    int exp_wa[$];
    int exp_wd[$];
    int exp_rd[$];

    wt_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ctl(cfg_ctl),
        .cfg_page(cfg_page), .cfg_fine(cfg_fine), .irq_ack(irq_ack),
        .go(go), .go_count(go_count), .go_wide(go_wide), .go_tc(go_tc),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy),
        .ctl_q(ctl_q), .page_q(page_q), .fine_q(fine_q), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic int memf(int a);
        return (a ^ (a >> 8) ^ 'h5A) & 'hFF;
    endfunction

    function automatic int start_addr(int pg, int fn, bit wide);
        int o;
        o = pg * 16 + fn;
        if (wide) o = (o & 'hC0000) + 2 * (o & 'h1FFF0);
        return o & 'hFFFFF;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Card RAM model: read data one cycle after the read enable.
    always @(posedge clk)
        if (ram_re) ram_rdata <= 8'(memf(int'(ram_addr)));

    // Stream drivers and per-clock comparison against the model queues.
    always @(negedge clk) begin
        src_valid = (src_q.size() > 0) && ($urandom_range(3) != 0);
        src_data  = (src_q.size() > 0) ? 8'(src_q[0]) : 8'h00;
        snk_ready = ($urandom_range(2) != 0);
        #1;
        if (monitor_on) begin
            if (ram_we) begin
                chk(src_valid, "R10 write without valid source", 0, 1);
                if (exp_wa.size() == 0) begin
                    chk(1'b0, "R9 unexpected RAM write", int'(ram_addr), -1);
                end else begin
                    chk(int'(ram_addr) == exp_wa[0], "R1/R2 write address",
                        int'(ram_addr), exp_wa[0]);
                    chk(int'(ram_wdata) == exp_wd[0], "R4/R5 write data",
                        int'(ram_wdata), exp_wd[0]);
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                end
                void'(src_q.pop_front());
            end
            if (snk_valid && snk_ready) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R3 unexpected sink byte", int'(snk_data), -1);
                end else begin
                    chk(int'(snk_data) == exp_rd[0], "R3/R4 sink data",
                        int'(snk_data), exp_rd[0]);
                    void'(exp_rd.pop_front());
                end
            end
        end
    end

    task automatic run_block(int ctl, int pg, int fn, int cnt, bit wide, bit tc,
                             bit disturb);
        int nb, a0, ep, ef, ec;
        bit inv;
        @(negedge clk);
        irq_ack = 1'b1;
        cfg_wr = 1'b1; cfg_ctl = 8'(ctl); cfg_page = 16'(pg); cfg_fine = 4'(fn);
        @(negedge clk);
        irq_ack = 1'b0; cfg_wr = 1'b0;
        chk(irq == 1'b0, "R8 irq cleared by ack", irq, 0);
        nb = wide ? 2 * cnt : cnt;
        a0 = start_addr(pg, fn, wide);
        for (int i = 0; i < nb; i++) begin
            if (ctl[1]) begin
                exp_rd.push_back(memf((a0 + i) & 'hFFFFF));
            end else begin
                int b;
                b = $urandom_range(255);
                inv = ctl[7] && ((wide && (i % 2 == 1)) || !ctl[6]);
                src_q.push_back(b);
                exp_wa.push_back((a0 + i) & 'hFFFFF);
                exp_wd.push_back(inv ? (b ^ 'h80) : b);
            end
        end
        go = 1'b1; go_count = 16'(cnt); go_wide = wide; go_tc = tc;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        if (disturb && busy) begin
            repeat (3) @(negedge clk);
            go = 1'b1; go_count = 16'd50;
            cfg_wr = 1'b1; cfg_page = 16'h1234; cfg_ctl = 8'hFF;
            @(negedge clk);
            go = 1'b0; cfg_wr = 1'b0;
            chk(ctl_q[0] == ctl[0], "R7 request kept mid-block", ctl_q[0], ctl[0]);
        end
        while (busy) @(negedge clk);
        ep = (pg + (cnt >> 4)) & 'hFFFF;
        ef = (cnt + fn) & 'hF;
        ec = tc ? (ctl & 'hFE) : ctl;
        chk(exp_wa.size() == 0 && exp_rd.size() == 0, "R3/R9 all bytes moved",
            exp_wa.size() + exp_rd.size(), 0);
        chk(int'(page_q) == ep, "R6/R11 page after block", page_q, ep);
        chk(int'(fine_q) == ef, "R6 fine after block", fine_q, ef);
        chk(int'(ctl_q) == ec, "R7/R11 control after block", ctl_q, ec);
        chk(irq == (tc && ctl[5]), "R8 irq after block", irq, tc && ctl[5]);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && irq == (tc && ctl[5]), "R9/R8 idle and irq held",
            {busy, irq}, {1'b0, tc && ctl[5]});
    endtask

    initial begin
        #3000000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(busy == 0 && irq == 0 && ram_we == 0 && ram_re == 0, "R12 reset outputs",
            {busy, irq, ram_we, ram_re}, 0);
        chk(ctl_q == 0 && page_q == 0 && fine_q == 0, "R12 reset registers",
            {ctl_q, page_q, fine_q}, 0);
        monitor_on = 1'b1;
        run_block('h21, 'h0012, 3, 5, 0, 1, 0);     // R1 R7 R8: plain, interrupt
        run_block('h81, 'h0100, 8, 20, 0, 0, 0);    // R4 R6: inverted, page carry
        run_block('hC1, 'hC123, 5, 6, 1, 1, 0);     // R2 R5: 16-bit, no irq enable
        run_block('h83, 'h0040, 2, 7, 0, 0, 0);     // R3 R4: from card, no inversion
        run_block('h42, 'h4444, 1, 3, 1, 1, 0);     // R2 R3: 16-bit from card
        run_block('h01, 'hFFFF, 14, 40, 0, 0, 1);   // R1 R9 R11: wrap, disturbances
        run_block('h21, 'h0777, 9, 0, 0, 1, 0);     // R9: zero count
        run_block('hC0, 'h0020, 0, 3, 0, 0, 0);     // R5: 8-bit low byte plain
        run_block('h85, 'h0300, 15, 33, 1, 1, 0);   // R5 R6: 16-bit inverted
        monitor_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule